// File: doc/BRIEF.md
# Ping-Pong Output Address Controller

This block keeps two complete sets of output frame base addresses, one set for each half of a ping-pong buffer pair. Each set holds a luma plane address and two chroma plane addresses. The set of the active slot drives a downstream frame writer. At each frame end the controller moves to the other slot, but only when software has armed that slot with a fresh set. When the other slot is not armed, the controller keeps the current slot and flags an overflow for that frame.

Software writes the address registers through a simple register port. The written addresses go into shadow storage and do not reach the writer yet. A set is armed by inverting that slot's load bit in the control register. Writing the bit back with the value it already holds does nothing. If the slot being armed is the one in use, the new set waits and is applied at the next frame start. Each plane address can carry an optional extension field above bit 31.

The same control register holds three per-plane panic thresholds. A 13-bit status register collects the frame-done, write-error, overflow, excess-overflow and panic events. Software clears status bits by writing ones to them. An enable mask selects which status bits raise the single interrupt line.

Top module: `pp_addr_ctrl`

## Requirements
- R1: After reset the active slot is 0, all three address outputs are zero, the status register reads zero and irq_o is low.
- R2: Register word addresses are as follows.
  - Control is at 0. It reads back as load bits [1:0], bits [7:2] as zero, and the Y/U/V thresholds at [15:8]/[23:16]/[31:24].
  - Status is at 1 and the enable mask is at 2.
  - Slot registers use addr[4:3] (01 for slot 0, 10 for slot 1), addr[2] (1 selects the extension field) and addr[1:0] (0=Y, 1=U, 2=V).
  - Shadow registers read back what was written, and extension registers return only their low 4 bits.
- R3: Inverting the load bit of the inactive slot copies its shadow set into that slot and arms it. A control write that leaves a load bit at its current value neither copies nor arms that slot.
- R4: Inverting the load bit of the active slot leaves the outputs unchanged until the next frame_start_i pulse, which then applies the new set.
- R5: On frame_end_i the active slot changes to the other slot only if that slot was armed since it was last used; the switch consumes the arming. The slot changes at no other time.
- R6: On frame_end_i with the other slot not armed, the slot stays and status bits [6:4] are all set.
- R7: Each address output is {4-bit extension, 32-bit low word} of the active slot's applied set. Shadow writes alone never change an output.
- R8: The status register bits are as follows.
  - Bit 0 is set by frame_end_i.
  - Bits [3:1] are set by wr_err_i, bits [6:4] by ovf_i and bits [9:7] by excs_ovf_i, each in Y/U/V order.
- R9: Panic status bit 10+p is set in any cycle where plane p's threshold is nonzero and its fill level is at or above the threshold. A zero threshold never sets it.
- R10: Writing the status register clears exactly the bits written as one. A bit whose event fires in the same cycle stays set.
- R11: irq_o is the OR of status ANDed with the enable mask. It falls in the cycle after the last enabled bit is cleared, and an all-zero mask holds it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| frame_start_i | input | 1 | Frame start pulse |
| frame_end_i | input | 1 | Frame end pulse |
| wr_err_i | input | 3 | Per-plane write error events |
| ovf_i | input | 3 | Per-plane overflow events |
| excs_ovf_i | input | 3 | Per-plane excess overflow events |
| fill_lvl_i | input | 24 | Per-plane fill levels, Y in the low byte |
| act_slot_o | output | 1 | Active slot index |
| addr_y_o | output | 36 | Active luma base address |
| addr_u_o | output | 36 | Active first chroma base address |
| addr_v_o | output | 36 | Active second chroma base address |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench checks the following cases.
- **Load bit rewritten with its current value.** A design that armed on level instead of edge would switch slots at the next frame end instead of flagging overflow.
- **Active slot armed mid-frame.** A design that applied the set at once would move the writer's address during the frame.
- **Status clear and set in the same cycle.** A wrong priority would lose an event.
- **Timing of the interrupt drop.** irq_o must fall on the cycle after the clearing write.
- **Threshold exactly equal to the fill level, and a zero threshold with a full buffer.** These catch an off-by-one compare and a missing zero guard.

Random register traffic and frame pulses are checked every cycle against a bench model of the slot, arming and status rules.

// File: rtl/pp_addr_pkg.sv
package pp_addr_pkg;
  localparam int NPLANE = 3;
  localparam int STS_W  = 13;
  // status bit positions
  localparam int B_FRM   = 0;
  localparam int B_WERR  = 1;
  localparam int B_OVF   = 4;
  localparam int B_EXCS  = 7;
  localparam int B_PANIC = 10;
  // register words
  localparam logic [4:0] A_CTRL = 5'd0;
  localparam logic [4:0] A_STS  = 5'd1;
  localparam logic [4:0] A_IEN  = 5'd2;
  localparam int THR_LSB = 8;
endpackage

// File: rtl/pp_slot_bank.sv
module pp_slot_bank #(
  parameter int EXT_W  = 4,
  parameter bit EXT_EN = 1'b1,
  localparam int ADDR_W = 32 + EXT_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic                  hi_i,
  input  logic [1:0]            plane_i,
  input  logic [31:0]           wdata_i,
  input  logic                  commit_i,
  output logic [31:0]           rdata_o,
  output logic [3*ADDR_W-1:0]   live_o
);
  logic [31:0]      lo_rd [4];
  logic [EXT_W-1:0] hi_rd [4];

  assign lo_rd[3] = '0;
  assign hi_rd[3] = '0;

  for (genvar p = 0; p < 3; p++) begin : g_plane
    logic [31:0]       lo_q;
    logic [EXT_W-1:0]  hi_q;
    logic [ADDR_W-1:0] live_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lo_q <= '0;
      else if (we_i && !hi_i && plane_i == 2'(p)) lo_q <= wdata_i;
    end

    if (EXT_EN) begin : g_ext
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hi_q <= '0;
        else if (we_i && hi_i && plane_i == 2'(p)) hi_q <= wdata_i[EXT_W-1:0];
      end
    end else begin : g_noext
      assign hi_q = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       live_q <= '0;
      else if (commit_i) live_q <= {hi_q, lo_q};
    end

    assign lo_rd[p] = lo_q;
    assign hi_rd[p] = hi_q;
    assign live_o[p*ADDR_W +: ADDR_W] = live_q;
  end

  assign rdata_o = hi_i ? 32'(hi_rd[plane_i]) : lo_rd[plane_i];
endmodule

// File: rtl/pp_irq_ctrl.sv
module pp_irq_ctrl
  import pp_addr_pkg::*;
#(
  parameter int FILL_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sts_we_i,
  input  logic                     ien_we_i,
  input  logic [STS_W-1:0]         wdata_i,
  input  logic                     frame_done_i,
  input  logic                     starve_i,
  input  logic [NPLANE-1:0]        wr_err_i,
  input  logic [NPLANE-1:0]        ovf_i,
  input  logic [NPLANE-1:0]        excs_i,
  input  logic [NPLANE*FILL_W-1:0] fill_i,
  input  logic [NPLANE*FILL_W-1:0] thr_i,
  output logic [STS_W-1:0]         sts_o,
  output logic [STS_W-1:0]         ien_o,
  output logic                     irq_o
);
  logic [NPLANE-1:0] panic;
  logic [STS_W-1:0]  set_v, clr_v, sts_q, ien_q;

  for (genvar p = 0; p < NPLANE; p++) begin : g_panic
    logic [FILL_W-1:0] thr, lvl;
    assign thr = thr_i[p*FILL_W +: FILL_W];
    assign lvl = fill_i[p*FILL_W +: FILL_W];
    assign panic[p] = (thr != '0) && (lvl >= thr);
  end

  always_comb begin
    set_v = '0;
    set_v[B_FRM] = frame_done_i;
    set_v[B_WERR  +: NPLANE] = wr_err_i;
    set_v[B_OVF   +: NPLANE] = ovf_i | {NPLANE{starve_i}};
    set_v[B_EXCS  +: NPLANE] = excs_i;
    set_v[B_PANIC +: NPLANE] = panic;
    clr_v = sts_we_i ? wdata_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      ien_q <= '0;
    end else begin
      sts_q <= (sts_q & ~clr_v) | set_v;  // set wins over clear
      if (ien_we_i) ien_q <= wdata_i;
    end
  end

  assign sts_o = sts_q;
  assign ien_o = ien_q;
  assign irq_o = |(sts_q & ien_q);
endmodule

// File: rtl/pp_addr_ctrl.sv
module pp_addr_ctrl
  import pp_addr_pkg::*;
#(
  parameter int EXT_W  = 4,
  parameter bit EXT_EN = 1'b1,
  parameter int FILL_W = 8,
  localparam int ADDR_W = 32 + EXT_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     reg_we_i,
  input  logic [4:0]               reg_addr_i,
  input  logic [31:0]              reg_wdata_i,
  output logic [31:0]              reg_rdata_o,
  input  logic                     frame_start_i,
  input  logic                     frame_end_i,
  input  logic [2:0]               wr_err_i,
  input  logic [2:0]               ovf_i,
  input  logic [2:0]               excs_ovf_i,
  input  logic [3*FILL_W-1:0]      fill_lvl_i,
  output logic                     act_slot_o,
  output logic [ADDR_W-1:0]        addr_y_o,
  output logic [ADDR_W-1:0]        addr_u_o,
  output logic [ADDR_W-1:0]        addr_v_o,
  output logic                     irq_o
);
  logic [1:0]               load_q, ready_q, pend_q;
  logic [NPLANE*FILL_W-1:0] thr_q;
  logic                     act_q;
  logic                     ctrl_we, next_ok, do_switch, starve;
  logic [1:0]               tog, commit_now, fs_apply, commit;
  logic [31:0]              bank_rd [2];
  logic [3*ADDR_W-1:0]      bank_live [2];
  logic [STS_W-1:0]         sts_q, ien_q;

  assign ctrl_we   = reg_we_i && reg_addr_i == A_CTRL;
  assign next_ok   = ready_q[~act_q];
  assign do_switch = frame_end_i && next_ok;
  assign starve    = frame_end_i && !next_ok;

  for (genvar s = 0; s < 2; s++) begin : g_slot
    logic sel;
    assign sel           = reg_addr_i[4:3] == 2'(s + 1);
    assign tog[s]        = ctrl_we && (reg_wdata_i[s] != load_q[s]);
    assign commit_now[s] = tog[s] && (act_q != 1'(s));
    assign fs_apply[s]   = frame_start_i && pend_q[s] && (act_q == 1'(s));
    assign commit[s]     = commit_now[s] || fs_apply[s];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ready_q[s] <= 1'b0;
        pend_q[s]  <= 1'b0;
      end else begin
        if (commit_now[s])                          ready_q[s] <= 1'b1;
        else if (do_switch && act_q != 1'(s))       ready_q[s] <= 1'b0;
        if (tog[s] && act_q == 1'(s))               pend_q[s]  <= 1'b1;
        else if (commit[s])                         pend_q[s]  <= 1'b0;
      end
    end

    pp_slot_bank #(.EXT_W(EXT_W), .EXT_EN(EXT_EN)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (reg_we_i && sel),
      .hi_i     (reg_addr_i[2]),
      .plane_i  (reg_addr_i[1:0]),
      .wdata_i  (reg_wdata_i),
      .commit_i (commit[s]),
      .rdata_o  (bank_rd[s]),
      .live_o   (bank_live[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      thr_q  <= '0;
      act_q  <= 1'b0;
    end else begin
      if (ctrl_we) begin
        load_q <= reg_wdata_i[1:0];
        thr_q  <= reg_wdata_i[THR_LSB +: NPLANE*FILL_W];
      end
      if (do_switch) act_q <= ~act_q;
    end
  end

  pp_irq_ctrl #(.FILL_W(FILL_W)) u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sts_we_i     (reg_we_i && reg_addr_i == A_STS),
    .ien_we_i     (reg_we_i && reg_addr_i == A_IEN),
    .wdata_i      (reg_wdata_i[STS_W-1:0]),
    .frame_done_i (frame_end_i),
    .starve_i     (starve),
    .wr_err_i     (wr_err_i),
    .ovf_i        (ovf_i),
    .excs_i       (excs_ovf_i),
    .fill_i       (fill_lvl_i),
    .thr_i        (thr_q),
    .sts_o        (sts_q),
    .ien_o        (ien_q),
    .irq_o        (irq_o)
  );

  always_comb begin
    unique case (reg_addr_i[4:3])
      2'b01:   reg_rdata_o = bank_rd[0];
      2'b10:   reg_rdata_o = bank_rd[1];
      2'b00: begin
        if (reg_addr_i == A_CTRL)     reg_rdata_o = 32'({thr_q, 6'b0, load_q});
        else if (reg_addr_i == A_STS) reg_rdata_o = 32'(sts_q);
        else if (reg_addr_i == A_IEN) reg_rdata_o = 32'(ien_q);
        else                          reg_rdata_o = '0;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign act_slot_o = act_q;
  assign addr_y_o   = bank_live[act_q][0 +: ADDR_W];
  assign addr_u_o   = bank_live[act_q][ADDR_W +: ADDR_W];
  assign addr_v_o   = bank_live[act_q][2*ADDR_W +: ADDR_W];
endmodule

// File: rtl/pp_addr_ctrl_chk.sv
module pp_addr_ctrl_chk #(
  parameter int ADDR_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [4:0]        reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              frame_start_i,
  input logic              frame_end_i,
  input logic              act_slot_i,
  input logic [ADDR_W-1:0] addr_y_i,
  input logic              irq_i,
  input logic [12:0]       sts_i,
  input logic [12:0]       ien_i
);
  assert_slot_moves_at_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_slot_i) |-> $past(frame_end_i));

  assert_starve_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> (act_slot_i != $past(act_slot_i)) || (sts_i[6:4] == 3'b111));

  assert_frame_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> sts_i[0]);

  assert_addr_change_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(addr_y_i) |-> $past(frame_start_i || frame_end_i || (reg_we_i && reg_addr_i == 5'd0)));

  assert_mask_all_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 5'd2 && reg_wdata_i[12:0] == 13'd0) |=> !irq_i);

  assert_mask_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_i == 13'd0) |-> !irq_i);
endmodule

bind pp_addr_ctrl pp_addr_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_we_i      (reg_we_i),
  .reg_addr_i    (reg_addr_i),
  .reg_wdata_i   (reg_wdata_i),
  .frame_start_i (frame_start_i),
  .frame_end_i   (frame_end_i),
  .act_slot_i    (act_slot_o),
  .addr_y_i      (addr_y_o),
  .irq_i         (irq_o),
  .sts_i         (sts_q),
  .ien_i         (ien_q)
);

// File: tb/pp_addr_ctrl_bench.sv
module pp_addr_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        frame_start = 1'b0, frame_end = 1'b0;
  logic [2:0]  wr_err = '0, ovf = '0, excs = '0;
  logic [23:0] fill = '0;
  logic        act_slot, irq;
  logic [35:0] addr_y, addr_u, addr_v;

  int n_chk = 0;
  int n_fail = 0;

  // bench model
  bit [31:0] sh_lo [2][3];
  bit [3:0]  sh_hi [2][3];
  bit [35:0] lv [2][3];
  bit        m_act;
  bit [1:0]  m_rdy, m_pend, m_load;
  bit [12:0] m_sts, m_ien;
  bit [23:0] m_thr;

  always #10 clk = ~clk;

  pp_addr_ctrl u_pp_addr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .frame_start_i(frame_start),
    .frame_end_i(frame_end), .wr_err_i(wr_err), .ovf_i(ovf), .excs_ovf_i(excs),
    .fill_lvl_i(fill), .act_slot_o(act_slot), .addr_y_o(addr_y), .addr_u_o(addr_u),
    .addr_v_o(addr_v), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [12:0] panic_of(bit [23:0] thr, bit [23:0] lvl);
    bit [12:0] r = '0;
    for (int p = 0; p < 3; p++)
      r[10+p] = (thr[p*8 +: 8] != 0) && (lvl[p*8 +: 8] >= thr[p*8 +: 8]);
    return r;
  endfunction

  task automatic commit_slot(input int s);
    for (int p = 0; p < 3; p++) lv[s][p] = {sh_hi[s][p], sh_lo[s][p]};
  endtask

  // one clock of stimulus; called at a falling edge, returns at the next one
  task automatic cyc(input bit we, input bit [4:0] a, input bit [31:0] d,
                     input bit fs, input bit fe, input bit [2:0] e, input bit [2:0] o, input bit [2:0] x);
    bit oa;
    bit [12:0] set, clr;
    reg_we = we; reg_addr = a; reg_wdata = d;
    frame_start = fs; frame_end = fe; wr_err = e; ovf = o; excs = x;
    @(negedge clk);
    reg_we = 0; frame_start = 0; frame_end = 0; wr_err = 0; ovf = 0; excs = 0;
    oa = m_act;
    set = panic_of(m_thr, fill);
    set[0] = fe;
    set[3:1] = e; set[6:4] = o; set[9:7] = x;
    if (fe) begin
      if (m_rdy[~oa]) begin m_act = ~oa; m_rdy[~oa] = 0; end
      else set[6:4] = 3'b111;
    end
    if (we && a == 5'd0) begin
      for (int s = 0; s < 2; s++)
        if (d[s] != m_load[s]) begin
          if (oa == 1'(s)) m_pend[s] = 1;
          else begin commit_slot(s); m_rdy[s] = 1; m_pend[s] = 0; end
        end
      m_load = d[1:0];
      m_thr = d[31:8];
    end
    if (fs && m_pend[oa]) begin commit_slot(oa); m_pend[oa] = 0; end
    if (we && (a[4:3] == 2'b01 || a[4:3] == 2'b10) && a[1:0] != 2'd3) begin
      if (a[2]) sh_hi[a[4:3]-1][a[1:0]] = d[3:0];
      else      sh_lo[a[4:3]-1][a[1:0]] = d;
    end
    clr = (we && a == 5'd1) ? d[12:0] : '0;
    m_sts = (m_sts & ~clr) | set;
    if (we && a == 5'd2) m_ien = d[12:0];
    chk(act_slot == m_act, "R5 slot", 64'(act_slot), 64'(m_act));
    chk(addr_y == lv[m_act][0], "R7 addr_y", 64'(addr_y), 64'(lv[m_act][0]));
    chk(addr_u == lv[m_act][1], "R7 addr_u", 64'(addr_u), 64'(lv[m_act][1]));
    chk(addr_v == lv[m_act][2], "R7 addr_v", 64'(addr_v), 64'(lv[m_act][2]));
    chk(irq == |(m_sts & m_ien), "R11 irq", 64'(irq), 64'(|(m_sts & m_ien)));
  endtask

  task automatic idle();
    cyc(0, 5'd0, 0, 0, 0, 3'd0, 3'd0, 3'd0);
  endtask

  task automatic wr(input bit [4:0] a, input bit [31:0] d);
    cyc(1, a, d, 0, 0, 3'd0, 3'd0, 3'd0);
  endtask

  task automatic rd(input bit [4:0] a, input bit [31:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(act_slot == 0, "R1 slot", 64'(act_slot), 0);
    chk(addr_y == 0 && addr_u == 0 && addr_v == 0, "R1 addr", 64'(addr_y | addr_u | addr_v), 0);
    chk(irq == 0, "R1 irq", 64'(irq), 0);
    rd(5'd1, 32'd0, "R1 status");
    // R2 readback
    wr(5'b10001, 32'h1234_5678);
    rd(5'b10001, 32'h1234_5678, "R2 slot1 U");
    wr(5'b01110, 32'hFFFF_FFFF);
    rd(5'b01110, 32'h0000_000F, "R2 ext mask");
    // R3 / R5 / R7: arm inactive slot 1, then switch
    wr(5'b10000, 32'hAAAA_0000);
    wr(5'b10100, 32'h5);
    wr(5'd0, 32'h2);
    chk(addr_y == 36'h0, "R3 no output change", 64'(addr_y), 0);
    cyc(0, 5'd0, 0, 0, 1, 3'd0, 3'd0, 3'd0);
    chk(act_slot == 1, "R5 switched", 64'(act_slot), 1);
    chk(addr_y == 36'h5_AAAA_0000, "R7 ext addr", 64'(addr_y), 64'h5_AAAA_0000);
    // R3 same-value write ignored, R6 starve
    wr(5'd0, 32'h2);
    cyc(0, 5'd0, 0, 0, 1, 3'd0, 3'd0, 3'd0);
    chk(act_slot == 1, "R3 no arm on same value", 64'(act_slot), 1);
    rd(5'd1, 32'h71, "R6 overflow flags");
    // R4 arm active slot: held to frame start
    wr(5'b10000, 32'hBBBB_0000);
    wr(5'd0, 32'h0);
    chk(addr_y == 36'h5_AAAA_0000, "R4 held", 64'(addr_y), 64'h5_AAAA_0000);
    cyc(0, 5'd0, 0, 1, 0, 3'd0, 3'd0, 3'd0);
    chk(addr_y == 36'h5_BBBB_0000, "R4 applied", 64'(addr_y), 64'h5_BBBB_0000);
    // R10 write-one-to-clear
    wr(5'd1, 32'h1);
    rd(5'd1, 32'h70, "R10 partial clear");
    wr(5'd1, 32'h1FFF);
    rd(5'd1, 32'h0, "R10 full clear");
    // R10 set wins over same-cycle clear
    cyc(1, 5'd1, 32'h1FFF, 0, 0, 3'b001, 3'd0, 3'd0);
    rd(5'd1, 32'h2, "R10 set wins");
    wr(5'd1, 32'h1FFF);
    // R11 irq timing
    wr(5'd2, 32'h1);
    cyc(0, 5'd0, 0, 0, 1, 3'd0, 3'd0, 3'd0);
    chk(irq == 1, "R11 irq raised", 64'(irq), 1);
    wr(5'd1, 32'h1);
    chk(irq == 0, "R11 irq drop", 64'(irq), 0);
    wr(5'd2, 32'h0);
    wr(5'd1, 32'h1FFF);
    // R9 panic thresholds
    wr(5'd0, 32'h0000_1000);
    rd(5'd0, 32'h0000_1000, "R2 ctrl readback");
    fill = 24'h00FF0F;
    idle();
    rd(5'd1, 32'h0, "R9 below threshold / zero threshold");
    fill = 24'h00FF10;
    idle();
    rd(5'd1, 32'h400, "R9 at threshold");
    fill = '0;
    wr(5'd0, 32'h0);
    wr(5'd1, 32'h1FFF);
    // R8 event bits
    cyc(0, 5'd0, 0, 0, 0, 3'b010, 3'd0, 3'd0);
    rd(5'd1, 32'h4, "R8 wr_err U");
    cyc(0, 5'd0, 0, 0, 0, 3'd0, 3'b001, 3'b100);
    rd(5'd1, 32'h214, "R8 ovf Y excs V");
    wr(5'd1, 32'h1FFF);
    // random traffic against model
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom % 10);
      int s = int'($urandom % 2);
      bit [1:0] pl = 2'($urandom % 3);
      case (r)
        0, 1, 2: wr({2'(s + 1), 1'($urandom % 2), pl}, $urandom);
        3, 4: begin
          bit [1:0] ld = m_load;
          if ($urandom % 4 != 0) ld[s] = ~ld[s];
          wr(5'd0, {24'd0, 6'd0, ld});
        end
        5: cyc(0, 5'd0, 0, 1, 0, 3'd0, 3'd0, 3'd0);
        6, 7: cyc(0, 5'd0, 0, 0, 1, 3'd0, 3'd0, 3'd0);
        8: wr(5'd1, $urandom);
        default: begin
          if ($urandom % 2 == 1) wr(5'd2, $urandom);
          else cyc(0, 5'd0, 0, 0, 0, 3'($urandom), 3'($urandom), 3'($urandom));
        end
      endcase
      if (i % 50 == 0) rd(5'd1, 32'(m_sts), "R8 status model");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule